// File: doc/BRIEF.md
# Bus Trace Trigger Unit

This block sits next to a processor bus and watches each access through two reference values, A and B. A four-bit mode code selects how the comparator results combine into a trigger. The trigger then drives a small capture buffer. The block supports single-address, either-address and sequential matching, address-plus-data matching, inclusive and exclusive range tests, and event modes that log data bytes. Any other code disables triggering.

Software loads the reference values and the control field while the unit is disarmed, then sets the arm bit. In end-trace fashion, the buffer records every access circularly and stops at the trigger. In begin-trace fashion, recording starts with the triggering access and stops when the buffer is full. In both cases the arm bit drops when the run is over. Software can then pop the captured words, oldest first.

For the simple address modes, a hit can be deferred until the processor confirms that the instruction fetched from the hit address actually executed. The fetch address is held in a small pending table until an execute report for it arrives, or until a flush clears the table.

Top module: `bus_trace_trigger`

## Requirements
- R1: After reset, the control readback is 0, the arm bit is 0, the buffer count is 0, and `trig_o` and `fifo_wr_o` are low.
- R2: `cfg_sel` picks the register: 0 is reference A, 1 is reference B, 2 is control, 3 is arm (bit 0). In control, bit 7 is tag qualify, bit 6 is begin-trace and bits 3:0 are the mode. Bits 5:4 always read 0.
- R3: A control write made while armed leaves the control register unchanged. Reference writes are always accepted.
- R4: Mode 0 triggers on an access whose address equals A. Mode 1 triggers when the address equals A or B. `trig_o` pulses in the cycle after the access.
- R5: Mode 2 triggers on a B-address access only if an A-address access happened on an earlier cycle of the same armed run. An access that hits A and B at once only sets the sequence state. Disarming clears that state.
- R6: Mode 5 triggers when the address equals A and the data byte equals the low DW bits of B. Mode 6 triggers when the address equals A and the data byte differs from them.
- R7: Mode 7 triggers when A ≤ address ≤ B. Mode 8 triggers when address < A or address > B.
- R8: Codes 9 to 15 never trigger.
- R9: With tag qualify set in modes 0 to 2, only fetch accesses that hit are recorded. The hit counts when `exec_valid` reports that address. `tag_flush` drops all pending hits. In the other modes the tag bit has no effect.
- R10: End trace (bit 6 = 0) records every access address circularly and keeps the latest DEPTH entries, including the triggering access. The arm bit then clears.
- R11: Begin trace (bit 6 = 1) records addresses from the triggering access on. The arm bit clears when DEPTH entries are held, and later accesses are not stored.
- R12: Mode 3 treats every B-address access as an event. Mode 4 does the same, but only after an A-address access. Each event pulses `trig_o` and stores the data byte. Bit 6 is ignored, and the arm bit clears when the buffer is full.
- R13: In non-event modes, `trig_o` pulses at most once per armed run. Arming empties the buffer. Pops are taken only while disarmed, and `fifo_rdata` shows the oldest entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_valid | input | 1 | Bus access strobe |
| bus_addr | input | AW | Access address |
| bus_data | input | DW | Access data byte |
| bus_fetch | input | 1 | Access is an opcode fetch |
| exec_valid | input | 1 | Instruction-executed report |
| exec_addr | input | AW | Address of the executed instruction |
| tag_flush | input | 1 | Drop pending tagged hits |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select |
| cfg_wdata | input | AW | Register write data |
| cfg_rdata | output | AW | Selected register readback |
| fifo_pop | input | 1 | Remove oldest entry (disarmed only) |
| trig_o | output | 1 | Trigger or event pulse |
| fifo_wr_o | output | 1 | Buffer write strobe |
| fifo_wdata_o | output | AW | Word just written |
| fifo_count | output | $clog2(DEPTH+1) | Valid entries held |
| fifo_rdata | output | AW | Oldest held entry |

## Verification
The bench builds the unit with 8-bit addresses and data, a four-entry buffer and two pending tag slots. With 8-bit addresses, every address in the space can be swept for the equality and range modes, and every data byte for the data modes. Each expected trigger is computed from a plain comparison in the bench. The four-entry buffer makes wrap, fill and the automatic disarm reachable within a handful of accesses. The two tag slots make it easy to see fetch recording, mismatched execute reports and flushes.

// File: rtl/btt_pkg.sv
package btt_pkg;
   localparam logic [3:0] MODE_A_ONLY      = 4'd0;
   localparam logic [3:0] MODE_A_OR_B      = 4'd1;
   localparam logic [3:0] MODE_A_THEN_B    = 4'd2;
   localparam logic [3:0] MODE_EV_B        = 4'd3;
   localparam logic [3:0] MODE_A_THEN_EV_B = 4'd4;
   localparam logic [3:0] MODE_ADDR_DATA   = 4'd5;
   localparam logic [3:0] MODE_ADDR_NDATA  = 4'd6;
   localparam logic [3:0] MODE_INSIDE      = 4'd7;
   localparam logic [3:0] MODE_OUTSIDE     = 4'd8;

   localparam logic [1:0] SEL_REF_A = 2'd0;
   localparam logic [1:0] SEL_REF_B = 2'd1;
   localparam logic [1:0] SEL_CTRL  = 2'd2;
   localparam logic [1:0] SEL_ARM   = 2'd3;

   function automatic logic is_event_mode(input logic [3:0] m);
      return (m == MODE_EV_B) || (m == MODE_A_THEN_EV_B);
   endfunction

   function automatic logic tag_capable(input logic [3:0] m);
      return m <= MODE_A_THEN_B;
   endfunction
endpackage

// File: rtl/btt_match.sv
module btt_match #(
   parameter int AW = 16,
   parameter int DW = 8
)(
   input  logic [AW-1:0] addr,
   input  logic [DW-1:0] data,
   input  logic [AW-1:0] ref_a,
   input  logic [AW-1:0] ref_b,
   output logic          eq_a,
   output logic          eq_b,
   output logic          data_eq,
   output logic          in_range,
   output logic          out_range
);
   generate
      if (DW > AW) begin : g_bad_dw
         $error("btt_match: DW must not exceed AW");
      end
   endgenerate

   assign eq_a      = (addr == ref_a);
   assign eq_b      = (addr == ref_b);
   assign data_eq   = (data == ref_b[DW-1:0]);
   assign in_range  = (addr >= ref_a) && (addr <= ref_b);
   assign out_range = (addr < ref_a) || (addr > ref_b);
endmodule

// File: rtl/btt_tag_queue.sv
module btt_tag_queue #(
   parameter int AW    = 16,
   parameter int SLOTS = 4
)(
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          ins_valid,
   input  logic [AW-1:0] ins_addr,
   input  logic          ins_a,
   input  logic          ins_b,
   input  logic          exec_valid,
   input  logic [AW-1:0] exec_addr,
   output logic          hit_a,
   output logic          hit_b
);
   generate
      if (SLOTS < 1) begin : g_bad_slots
         $error("btt_tag_queue: SLOTS must be at least 1");
      end
   endgenerate

   logic [SLOTS-1:0] vld_q, kind_a_q, kind_b_q, match, free_pick;
   logic [AW-1:0]    addr_q [SLOTS];
   logic             found;

   genvar s;
   generate
      for (s = 0; s < SLOTS; s++) begin : g_slot
         assign match[s] = exec_valid && vld_q[s] && (addr_q[s] == exec_addr);
      end
   endgenerate

   assign hit_a = |(match & kind_a_q);
   assign hit_b = |(match & kind_b_q);

   always_comb begin
      free_pick = '0;
      found     = 1'b0;
      for (int i = 0; i < SLOTS; i++) begin
         if (!vld_q[i] && !found) begin
            free_pick[i] = 1'b1;
            found        = 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_q    <= '0;
         kind_a_q <= '0;
         kind_b_q <= '0;
         for (int i = 0; i < SLOTS; i++) addr_q[i] <= '0;
      end else if (clr) begin
         vld_q <= '0;
      end else begin
         for (int i = 0; i < SLOTS; i++) begin
            if (match[i]) vld_q[i] <= 1'b0;
            if (ins_valid && free_pick[i]) begin
               vld_q[i]    <= 1'b1;
               addr_q[i]   <= ins_addr;
               kind_a_q[i] <= ins_a;
               kind_b_q[i] <= ins_b;
            end
         end
      end
   end

   // R9
   flush_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> !(hit_a || hit_b));
endmodule

// File: rtl/btt_capture_fifo.sv
module btt_capture_fifo #(
   parameter int W     = 16,
   parameter int DEPTH = 8
)(
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       clr,
   input  logic                       push,
   input  logic [W-1:0]               din,
   input  logic                       pop,
   output logic [$clog2(DEPTH+1)-1:0] count,
   output logic [W-1:0]               rdata
);
   localparam int PW = $clog2(DEPTH);
   localparam int CW = $clog2(DEPTH+1);

   generate
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("btt_capture_fifo: DEPTH must be a power of two >= 2");
      end
   endgenerate

   logic [W-1:0]  mem [DEPTH];
   logic [PW-1:0] wp_q, rp;
   logic [CW-1:0] cnt_q;
   logic          full, do_pop;

   assign full   = (cnt_q == CW'(DEPTH));
   assign do_pop = pop && (cnt_q != '0) && !push;
   assign rp     = wp_q - PW'(cnt_q);
   assign rdata  = mem[rp];
   assign count  = cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp_q  <= '0;
         cnt_q <= '0;
         for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      end else if (clr) begin
         wp_q  <= '0;
         cnt_q <= '0;
      end else if (push) begin
         mem[wp_q] <= din;
         wp_q      <= wp_q + 1'b1;
         if (!full) cnt_q <= cnt_q + 1'b1;
      end else if (do_pop) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   // R10
   count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CW'(DEPTH));

   // R10
   wrap_keeps_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (push && full && !clr) |=> (cnt_q == CW'(DEPTH)));

   // R13
   clear_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (cnt_q == '0));
endmodule

// File: rtl/bus_trace_trigger.sv
module bus_trace_trigger
   import btt_pkg::*;
#(
   parameter int AW        = 16,
   parameter int DW        = 8,
   parameter int DEPTH     = 8,
   parameter int TAG_SLOTS = 4
)(
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       bus_valid,
   input  logic [AW-1:0]              bus_addr,
   input  logic [DW-1:0]              bus_data,
   input  logic                       bus_fetch,
   input  logic                       exec_valid,
   input  logic [AW-1:0]              exec_addr,
   input  logic                       tag_flush,
   input  logic                       cfg_we,
   input  logic [1:0]                 cfg_sel,
   input  logic [AW-1:0]              cfg_wdata,
   output logic [AW-1:0]              cfg_rdata,
   input  logic                       fifo_pop,
   output logic                       trig_o,
   output logic                       fifo_wr_o,
   output logic [AW-1:0]              fifo_wdata_o,
   output logic [$clog2(DEPTH+1)-1:0] fifo_count,
   output logic [AW-1:0]              fifo_rdata
);
   localparam int CW = $clog2(DEPTH+1);

   generate
      if (AW < 8 || DW > AW) begin : g_bad_width
         $error("bus_trace_trigger: need AW >= 8 and DW <= AW");
      end
   endgenerate

   logic [AW-1:0] ref_a_q, ref_b_q;
   logic [3:0]    mode_q;
   logic          tag_q, start_q, arm_q, seq_q, trg_q;
   logic          eq_a, eq_b, data_eq, in_rng, out_rng;
   logic          tq_a, tq_b;
   logic          ev_mode, use_tag, fa, fb, qa, qb, ins;
   logic          hit, fire, event_now, seq_set, push, stop;
   logic          ctrl_wr, arming, disarm;
   logic [AW-1:0] pdata;
   logic [CW-1:0] cnt;

   btt_match #(.AW(AW), .DW(DW)) match_i (
      .addr(bus_addr), .data(bus_data), .ref_a(ref_a_q), .ref_b(ref_b_q),
      .eq_a(eq_a), .eq_b(eq_b), .data_eq(data_eq),
      .in_range(in_rng), .out_range(out_rng)
   );

   assign ev_mode = is_event_mode(mode_q);
   assign use_tag = tag_q && tag_capable(mode_q);
   assign fa      = bus_valid && eq_a;
   assign fb      = bus_valid && eq_b;
   assign ins     = arm_q && use_tag && bus_valid && bus_fetch && (eq_a || eq_b);

   btt_tag_queue #(.AW(AW), .SLOTS(TAG_SLOTS)) tagq_i (
      .clk(clk), .rst_n(rst_n), .clr(tag_flush || !arm_q),
      .ins_valid(ins), .ins_addr(bus_addr), .ins_a(eq_a), .ins_b(eq_b),
      .exec_valid(exec_valid), .exec_addr(exec_addr),
      .hit_a(tq_a), .hit_b(tq_b)
   );

   assign qa = use_tag ? tq_a : fa;
   assign qb = use_tag ? tq_b : fb;

   always_comb begin
      unique case (mode_q)
         MODE_A_ONLY:     hit = qa;
         MODE_A_OR_B:     hit = qa || qb;
         MODE_A_THEN_B:   hit = seq_q && qb;
         MODE_ADDR_DATA:  hit = fa && data_eq;
         MODE_ADDR_NDATA: hit = fa && !data_eq;
         MODE_INSIDE:     hit = bus_valid && in_rng;
         MODE_OUTSIDE:    hit = bus_valid && out_rng;
         default:         hit = 1'b0;
      endcase
   end

   assign fire      = arm_q && !trg_q && hit;
   assign event_now = arm_q && fb &&
                      ((mode_q == MODE_EV_B) || (mode_q == MODE_A_THEN_EV_B && seq_q));
   assign seq_set   = arm_q && (((mode_q == MODE_A_THEN_B) && qa) ||
                                ((mode_q == MODE_A_THEN_EV_B) && fa));

   always_comb begin
      if (ev_mode) begin
         push  = event_now;
         pdata = AW'(bus_data);
      end else if (start_q) begin
         push  = arm_q && bus_valid && (trg_q || fire);
         pdata = bus_addr;
      end else begin
         push  = arm_q && !trg_q && bus_valid;
         pdata = bus_addr;
      end
   end

   assign stop = arm_q && ((((ev_mode || start_q) && push && (cnt == CW'(DEPTH - 1)))) ||
                           (!ev_mode && !start_q && fire));

   btt_capture_fifo #(.W(AW), .DEPTH(DEPTH)) fifo_i (
      .clk(clk), .rst_n(rst_n), .clr(arming), .push(push), .din(pdata),
      .pop(fifo_pop && !arm_q), .count(cnt), .rdata(fifo_rdata)
   );

   assign ctrl_wr = cfg_we && (cfg_sel == SEL_CTRL) && !arm_q;
   assign arming  = cfg_we && (cfg_sel == SEL_ARM) && cfg_wdata[0] && !arm_q;
   assign disarm  = cfg_we && (cfg_sel == SEL_ARM) && !cfg_wdata[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ref_a_q      <= '0;
         ref_b_q      <= '0;
         mode_q       <= '0;
         tag_q        <= 1'b0;
         start_q      <= 1'b0;
         arm_q        <= 1'b0;
         seq_q        <= 1'b0;
         trg_q        <= 1'b0;
         trig_o       <= 1'b0;
         fifo_wr_o    <= 1'b0;
         fifo_wdata_o <= '0;
      end else begin
         if (cfg_we && cfg_sel == SEL_REF_A) ref_a_q <= cfg_wdata;
         if (cfg_we && cfg_sel == SEL_REF_B) ref_b_q <= cfg_wdata;
         if (ctrl_wr) begin
            tag_q   <= cfg_wdata[7];
            start_q <= cfg_wdata[6];
            mode_q  <= cfg_wdata[3:0];
         end
         if (arming)       arm_q <= 1'b1;
         else if (disarm)  arm_q <= 1'b0;
         else if (stop)    arm_q <= 1'b0;

         if (arming || disarm || !arm_q) seq_q <= 1'b0;
         else if (seq_set)               seq_q <= 1'b1;

         if (arming)    trg_q <= 1'b0;
         else if (fire) trg_q <= 1'b1;

         trig_o       <= fire || event_now;
         fifo_wr_o    <= push;
         fifo_wdata_o <= pdata;
      end
   end

   always_comb begin
      unique case (cfg_sel)
         SEL_REF_A: cfg_rdata = ref_a_q;
         SEL_REF_B: cfg_rdata = ref_b_q;
         SEL_CTRL:  cfg_rdata = AW'({tag_q, start_q, 2'b00, mode_q});
         default:   cfg_rdata = AW'(arm_q);
      endcase
   end

   assign fifo_count = cnt;

   // R3
   ctrl_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      arm_q |=> $stable({tag_q, start_q, mode_q}));

   // R13
   single_trig_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (trig_o && !ev_mode) |=> !trig_o);

   // R5
   seq_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !arm_q |=> !seq_q);
endmodule

// File: tb/bus_trace_trigger_tb_top.sv
`timescale 1ns/1ps
module bus_trace_trigger_tb_top;
   localparam int AW = 8, DW = 8, DEPTH = 4, SLOTS = 2;
   localparam int CW = $clog2(DEPTH+1);

   logic clk = 0, rst_n = 0;
   logic bus_valid = 0, bus_fetch = 0, exec_valid = 0, tag_flush = 0, cfg_we = 0, fifo_pop = 0;
   logic [AW-1:0] bus_addr = 0, exec_addr = 0, cfg_wdata = 0;
   logic [DW-1:0] bus_data = 0;
   logic [1:0] cfg_sel = 0;
   logic [AW-1:0] cfg_rdata, fifo_wdata_o, fifo_rdata;
   logic trig_o, fifo_wr_o;
   logic [CW-1:0] fifo_count;

   int checks = 0, errors = 0;
   bit done = 0;
   logic last_trig, last_wr;
   logic [AW-1:0] last_wd;

   always #5 clk = ~clk;

   bus_trace_trigger #(.AW(AW), .DW(DW), .DEPTH(DEPTH), .TAG_SLOTS(SLOTS)) dut_i (
      .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_addr(bus_addr),
      .bus_data(bus_data), .bus_fetch(bus_fetch), .exec_valid(exec_valid),
      .exec_addr(exec_addr), .tag_flush(tag_flush), .cfg_we(cfg_we),
      .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
      .fifo_pop(fifo_pop), .trig_o(trig_o), .fifo_wr_o(fifo_wr_o),
      .fifo_wdata_o(fifo_wdata_o), .fifo_count(fifo_count), .fifo_rdata(fifo_rdata)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic cfg_write(input logic [1:0] sel, input logic [7:0] val);
      @(negedge clk);
      cfg_we = 1; cfg_sel = sel; cfg_wdata = val;
      @(negedge clk);
      cfg_we = 0;
   endtask

   task automatic read_cfg(input logic [1:0] sel, output logic [7:0] val);
      cfg_sel = sel;
      #1;
      val = cfg_rdata;
   endtask

   task automatic setup(input logic [7:0] a, input logic [7:0] b, input logic [7:0] c);
      cfg_write(3, 0); cfg_write(0, a); cfg_write(1, b); cfg_write(2, c);
   endtask

   task automatic rearm();
      cfg_write(3, 0); cfg_write(3, 1);
   endtask

   task automatic access(input logic [7:0] a, input logic [7:0] d, input logic f);
      @(negedge clk);
      bus_valid = 1; bus_addr = a; bus_data = d; bus_fetch = f;
      @(negedge clk);
      bus_valid = 0; bus_fetch = 0;
      last_trig = trig_o; last_wr = fifo_wr_o; last_wd = fifo_wdata_o;
   endtask

   task automatic exec_rep(input logic [7:0] a);
      @(negedge clk);
      exec_valid = 1; exec_addr = a;
      @(negedge clk);
      exec_valid = 0;
      last_trig = trig_o;
   endtask

   task automatic flush();
      @(negedge clk); tag_flush = 1;
      @(negedge clk); tag_flush = 0;
   endtask

   task automatic pop_chk(input string req, input logic [7:0] exp);
      chk(req, fifo_rdata, exp);
      fifo_pop = 1;
      @(negedge clk);
      fifo_pop = 0;
   endtask

   initial begin
      #1_500_000;
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      logic [7:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R1 reset state
      read_cfg(2, v); chk("R1 ctrl", v, 0);
      read_cfg(3, v); chk("R1 arm", v, 0);
      chk("R1 count", fifo_count, 0);
      chk("R1 trig", trig_o, 0);
      chk("R1 wr", fifo_wr_o, 0);

      // R2 layout and reserved bits
      cfg_write(2, 8'hFF); read_cfg(2, v); chk("R2 mask", v, 8'hCF);
      cfg_write(0, 8'h12); read_cfg(0, v); chk("R2 refA", v, 8'h12);
      cfg_write(1, 8'h34); read_cfg(1, v); chk("R2 refB", v, 8'h34);

      // R3 locked while armed
      setup(8'h00, 8'h00, 8'h07); cfg_write(3, 1);
      cfg_write(2, 8'h00); read_cfg(2, v); chk("R3 locked", v, 8'h07);
      cfg_write(0, 8'h44); read_cfg(0, v); chk("R3 refA open", v, 8'h44);
      cfg_write(3, 0);

      // R4 mode 0 and mode 1 sweeps
      setup(8'h55, 8'hAA, 8'h00);
      for (int a = 0; a < 256; a++) begin
         rearm(); access(8'(a), 0, 0);
         chk("R4 mode0", last_trig, (a == 8'h55));
      end
      setup(8'h55, 8'hAA, 8'h01);
      for (int a = 0; a < 256; a++) begin
         rearm(); access(8'(a), 0, 0);
         chk("R4 mode1", last_trig, (a == 8'h55) || (a == 8'hAA));
      end

      // R5 sequence
      setup(8'h10, 8'h20, 8'h02); cfg_write(3, 1);
      access(8'h20, 0, 0); chk("R5 B first", last_trig, 0);
      access(8'h10, 0, 0); chk("R5 A", last_trig, 0);
      access(8'h20, 0, 0); chk("R5 A then B", last_trig, 1);
      setup(8'h30, 8'h30, 8'h02); cfg_write(3, 1);
      access(8'h30, 0, 0); chk("R5 same cycle", last_trig, 0);
      access(8'h30, 0, 0); chk("R5 later B", last_trig, 1);
      setup(8'h10, 8'h20, 8'h02); cfg_write(3, 1);
      access(8'h10, 0, 0); rearm();
      access(8'h20, 0, 0); chk("R5 disarm clears", last_trig, 0);

      // R6 data modes
      setup(8'h20, 8'h3C, 8'h05);
      for (int d = 0; d < 256; d++) begin
         rearm(); access(8'h20, 8'(d), 0);
         chk("R6 mode5", last_trig, (d == 8'h3C));
      end
      rearm(); access(8'h21, 8'h3C, 0); chk("R6 wrong addr", last_trig, 0);
      setup(8'h20, 8'h3C, 8'h06);
      for (int d = 0; d < 256; d++) begin
         rearm(); access(8'h20, 8'(d), 0);
         chk("R6 mode6", last_trig, (d != 8'h3C));
      end

      // R7 range modes
      setup(8'h40, 8'h60, 8'h07);
      for (int a = 0; a < 256; a++) begin
         rearm(); access(8'(a), 0, 0);
         chk("R7 inside", last_trig, (a >= 8'h40) && (a <= 8'h60));
      end
      setup(8'h40, 8'h60, 8'h08);
      for (int a = 0; a < 256; a++) begin
         rearm(); access(8'(a), 0, 0);
         chk("R7 outside", last_trig, (a < 8'h40) || (a > 8'h60));
      end

      // R8 unused codes
      for (int m = 9; m < 16; m++) begin
         setup(8'h00, 8'hFF, 8'(m));
         for (int a = 0; a < 256; a += 17) begin
            rearm(); access(8'(a), 8'hFF, 1);
            chk("R8 no trigger", last_trig, 0);
         end
      end

      // R9 tag qualification
      setup(8'h50, 8'hEE, 8'h80); cfg_write(3, 1);
      access(8'h50, 0, 0); chk("R9 access force off", last_trig, 0);
      exec_rep(8'h50); chk("R9 nonfetch not kept", last_trig, 0);
      access(8'h50, 0, 1); chk("R9 fetch pending", last_trig, 0);
      exec_rep(8'h51); chk("R9 other exec", last_trig, 0);
      exec_rep(8'h50); chk("R9 executed", last_trig, 1);
      rearm();
      access(8'h50, 0, 1); flush();
      exec_rep(8'h50); chk("R9 flushed", last_trig, 0);
      setup(8'h40, 8'h60, 8'h87); cfg_write(3, 1);
      access(8'h50, 0, 0); chk("R9 tag ignored range", last_trig, 1);

      // R10 end trace
      setup(8'h80, 8'hEE, 8'h00); cfg_write(3, 1);
      for (int a = 1; a <= 6; a++) access(8'(a), 0, 0);
      access(8'h80, 0, 0); chk("R10 trig", last_trig, 1);
      read_cfg(3, v); chk("R10 disarmed", v, 0);
      chk("R10 count", fifo_count, 4);
      pop_chk("R10 e0", 8'h04); pop_chk("R10 e1", 8'h05);
      pop_chk("R10 e2", 8'h06); pop_chk("R10 e3", 8'h80);
      chk("R13 empty after pops", fifo_count, 0);

      // R11 begin trace
      setup(8'h80, 8'hEE, 8'h40); cfg_write(3, 1);
      access(8'h01, 0, 0); access(8'h02, 0, 0);
      chk("R11 nothing before trigger", fifo_count, 0);
      access(8'h80, 0, 0); chk("R11 trig", last_trig, 1);
      access(8'h80, 0, 0); chk("R13 once per run", last_trig, 0);
      access(8'h03, 0, 0); access(8'h04, 0, 0);
      read_cfg(3, v); chk("R11 disarmed when full", v, 0);
      access(8'h05, 0, 0); chk("R11 not stored", last_wr, 0);
      chk("R11 count", fifo_count, 4);
      pop_chk("R11 e0", 8'h80); pop_chk("R11 e1", 8'h80);
      pop_chk("R11 e2", 8'h03); pop_chk("R11 e3", 8'h04);

      // R12 event modes
      setup(8'h00, 8'h30, 8'h03); cfg_write(3, 1);
      access(8'h30, 8'hA1, 0);
      chk("R12 event trig", last_trig, 1);
      chk("R12 write strobe", last_wr, 1);
      chk("R12 write data", last_wd, 8'hA1);
      access(8'h31, 8'hFF, 0); chk("R12 non-B", last_trig, 0);
      access(8'h30, 8'hA2, 0); access(8'h30, 8'hA3, 0); access(8'h30, 8'hA4, 0);
      read_cfg(3, v); chk("R12 disarmed when full", v, 0);
      access(8'h30, 8'hA5, 0); chk("R12 after full", last_trig, 0);
      pop_chk("R12 d0", 8'hA1); pop_chk("R12 d1", 8'hA2);
      pop_chk("R12 d2", 8'hA3); pop_chk("R12 d3", 8'hA4);
      setup(8'h10, 8'h30, 8'h04); cfg_write(3, 1);
      access(8'h30, 8'hB1, 0); chk("R12 B before A", last_trig, 0);
      access(8'h10, 8'h00, 0); chk("R12 A arms events", last_trig, 0);
      access(8'h30, 8'hC1, 0); chk("R12 A then event", last_trig, 1);
      chk("R12 one entry", fifo_count, 1);
      chk("R12 entry", fifo_rdata, 8'hC1);

      // R13 pop ignored while armed, arming empties
      fifo_pop = 1; @(negedge clk); fifo_pop = 0;
      chk("R13 pop while armed", fifo_count, 1);
      rearm(); chk("R13 arming empties", fifo_count, 0);
      cfg_write(3, 0);

      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule